// File: doc/BRIEF.md
# Cache ECC Error Recovery Sequencer

This block steers one side of a cache (instruction or data, chosen by a parameter) through recovery after the ECC checker flags a bad read from a cache RAM. It takes in the failing set index and way, holds the requester off, and reports the location to the error bank so it can be masked. It then has the line invalidated. When the data side is configured, a dirty line is also cleaned: its corrected contents go to the write buffer for write-back to external memory. Only after that does the block tell the requester to replay its access.

On the instruction side, lines are never dirty, so the dirty input is ignored and an invalidate is always enough. The replayed fetch brings in fresh data from memory. On the data side, a dirty line whose error cannot be corrected has no good copy anywhere. The block then raises a sticky fatal flag instead of recovering. The flag stays up until software-side logic pulses the clear input. A clean line with an uncorrectable error is not fatal, because refetching repairs it.

The ECC logic, the cache arrays, the write buffer and external memory sit outside. They are reached through simple request/acknowledge and valid/ready ports.

Top module: `ecc_recovery_seq`

## Requirements
- R1: After reset, `busy`, `bank_push`, `inv_req`, `wb_valid`, `retry_pulse` and `fatal_err` are all 0.
- R2: An error is accepted on a clock edge where `err_valid` is 1 and `busy` is 0. In the following cycle, `busy` is 1 and `bank_push` is 1 for exactly that one cycle, with `bank_index`/`bank_way` equal to the accepted `err_index`/`err_way`.
- R3: For a recoverable error, `inv_req` rises in the cycle after the `bank_push` cycle. It carries the captured index and way, and stays 1 with a stable location until an edge samples `inv_done` at 1.
- R4: With `DATA_SIDE`=0, `line_dirty` has no effect and an uncorrectable error is not fatal. `wb_valid` never rises, and `retry_pulse` is 1 in the cycle after the edge that samples `inv_done`.
- R5: With `DATA_SIDE`=1, a dirty correctable line raises `wb_valid` in the cycle after `inv_done` is sampled, with the captured index and way. `wb_valid` holds until an edge samples `wb_ready` at 1, and `retry_pulse` follows in the next cycle.
- R6: With `DATA_SIDE`=1, a clean line, whether correctable or not, takes no write-back, and `retry_pulse` follows `inv_done` directly.
- R7: With `DATA_SIDE`=1, a dirty uncorrectable line sets `fatal_err` in the cycle after the `bank_push` cycle. `inv_req` and `retry_pulse` stay 0, and `busy` stays 1.
- R8: `fatal_err` stays 1 until an edge samples `fatal_clr` at 1. In the next cycle, `fatal_err` and `busy` are 0.
- R9: `retry_pulse` lasts exactly one cycle, and `busy` is 0 in the cycle after it.
- R10: `err_valid` asserted while `busy` is 1 is ignored: the location in progress does not change, and no second `bank_push` follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| err_valid | input | 1 | ECC checker reports an error on a cache read |
| err_index | input | IDX_W | Set index of the failing line |
| err_way | input | WAY_W | Way of the failing line |
| err_correctable | input | 1 | 1 when the error can be corrected |
| line_dirty | input | 1 | Failing line holds modified data (ignored on the instruction side) |
| busy | output | 1 | Recovery in progress; the requester is stalled and no new error is taken |
| bank_push | output | 1 | One-cycle push of the failing location to the error bank |
| bank_index | output | IDX_W | Index pushed to the error bank |
| bank_way | output | WAY_W | Way pushed to the error bank |
| inv_req | output | 1 | Clean-and-invalidate request to the cache array |
| inv_index | output | IDX_W | Index of the line to invalidate |
| inv_way | output | WAY_W | Way of the line to invalidate |
| inv_done | input | 1 | Cache array has finished the invalidate |
| wb_valid | output | 1 | Corrected line offered to the write buffer |
| wb_index | output | IDX_W | Index of the line being written back |
| wb_way | output | WAY_W | Way of the line being written back |
| wb_ready | input | 1 | Write buffer accepts the corrected line |
| retry_pulse | output | 1 | One-cycle signal telling the requester to replay its access |
| fatal_err | output | 1 | Sticky non-recoverable error flag |
| fatal_clr | input | 1 | Clears the fatal flag and releases the sequencer |

## Verification
The assertions assume the cache array raises `inv_done` only while `inv_req` is up, and that `err_valid` is meaningful only while `busy` is 0. The bench meets the first assumption by pulsing `inv_done` for a single cycle after a chosen number of wait cycles in which `inv_req` is held. It offers `wb_ready` the same way, only during the write-back phase. Errors raised while the block is busy are injected on purpose to exercise the ignore path, and these never coincide with an acknowledge.

// File: rtl/ecc_rec_pkg.sv
package ecc_rec_pkg;

  typedef enum logic [2:0] {
    ST_IDLE      = 3'd0,
    ST_CAPTURE   = 3'd1,
    ST_CLEAN_INV = 3'd2,
    ST_WAIT_WB   = 3'd3,
    ST_RETRY     = 3'd4,
    ST_FATAL     = 3'd5
  } seq_state_e;

  // Corrected data must reach memory before the copy is dropped.
  function automatic logic needs_writeback(logic data_side, logic dirty, logic corr);
    return data_side & dirty & corr;
  endfunction

  // The only copy of the data is damaged beyond repair.
  function automatic logic is_fatal(logic data_side, logic dirty, logic corr);
    return data_side & dirty & ~corr;
  endfunction

endpackage

// File: rtl/ecc_rec_capture.sv
module ecc_rec_capture #(
  parameter int IDX_W = 7,
  parameter int WAY_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [IDX_W-1:0] idx_in,
  input  logic [WAY_W-1:0] way_in,
  input  logic             corr_in,
  input  logic             dirty_in,
  output logic [IDX_W-1:0] idx_q,
  output logic [WAY_W-1:0] way_q,
  output logic             corr_q,
  output logic             dirty_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q   <= '0;
      way_q   <= '0;
      corr_q  <= 1'b1;
      dirty_q <= 1'b0;
    end else if (load) begin
      idx_q   <= idx_in;
      way_q   <= way_in;
      corr_q  <= corr_in;
      dirty_q <= dirty_in;
    end
  end

endmodule

// File: rtl/ecc_rec_fsm.sv
module ecc_rec_fsm
  import ecc_rec_pkg::*;
#(
  parameter bit DATA_SIDE = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic err_valid,
  input  logic wb_needed,
  input  logic fatal_hit,
  input  logic inv_done,
  input  logic wb_ready,
  input  logic fatal_clr,
  output logic busy,
  output logic accept,
  output logic bank_push,
  output logic inv_req,
  output logic inv_fire,
  output logic wb_valid,
  output logic wb_fire,
  output logic retry_pulse,
  output logic enter_fatal
);

  seq_state_e state_q, state_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  assign busy        = (state_q != ST_IDLE);
  assign accept      = (state_q == ST_IDLE) && err_valid;
  assign bank_push   = (state_q == ST_CAPTURE);
  assign inv_req     = (state_q == ST_CLEAN_INV);
  assign inv_fire    = inv_req && inv_done;
  assign wb_valid    = (state_q == ST_WAIT_WB);
  assign wb_fire     = wb_valid && wb_ready;
  assign retry_pulse = (state_q == ST_RETRY);
  assign enter_fatal = (state_q == ST_CAPTURE) && fatal_hit;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:      if (accept) state_d = ST_CAPTURE;
      ST_CAPTURE:   state_d = fatal_hit ? ST_FATAL : ST_CLEAN_INV;
      ST_CLEAN_INV: if (inv_done) state_d = (wb_needed && DATA_SIDE) ? ST_WAIT_WB : ST_RETRY;
      ST_WAIT_WB:   if (wb_ready) state_d = ST_RETRY;
      ST_RETRY:     state_d = ST_IDLE;
      ST_FATAL:     if (fatal_clr) state_d = ST_IDLE;
      default:      state_d = ST_IDLE;
    endcase
  end

  assert_bank_push_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
    bank_push |=> !bank_push);
  assert_inv_held_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (inv_req && !inv_done) |=> inv_req);
  assert_wb_held_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_valid && !wb_ready) |=> wb_valid);
  assert_no_wb_isd_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !DATA_SIDE |-> !wb_valid);
  assert_retry_after_clean_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(retry_pulse) |-> $past(inv_fire || wb_fire));
  assert_retry_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    retry_pulse |=> (!retry_pulse && !busy));
  assert_busy_ignores_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !bank_push) |=> !bank_push);

endmodule

// File: rtl/ecc_rec_fatal_flag.sv
module ecc_rec_fatal_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     flag_q <= 1'b0;
    else if (set_i) flag_q <= 1'b1;
    else if (clr_i) flag_q <= 1'b0;
  end

  assert_fatal_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q && !clr_i) |=> flag_q);
  assert_fatal_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q && clr_i && !set_i) |=> !flag_q);

endmodule

// File: rtl/ecc_recovery_seq.sv
module ecc_recovery_seq
  import ecc_rec_pkg::*;
#(
  parameter int IDX_W     = 7,
  parameter int WAY_W     = 2,
  parameter bit DATA_SIDE = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             err_valid,
  input  logic [IDX_W-1:0] err_index,
  input  logic [WAY_W-1:0] err_way,
  input  logic             err_correctable,
  input  logic             line_dirty,
  output logic             busy,
  output logic             bank_push,
  output logic [IDX_W-1:0] bank_index,
  output logic [WAY_W-1:0] bank_way,
  output logic             inv_req,
  output logic [IDX_W-1:0] inv_index,
  output logic [WAY_W-1:0] inv_way,
  input  logic             inv_done,
  output logic             wb_valid,
  output logic [IDX_W-1:0] wb_index,
  output logic [WAY_W-1:0] wb_way,
  input  logic             wb_ready,
  output logic             retry_pulse,
  output logic             fatal_err,
  input  logic             fatal_clr
);

  logic             accept;
  logic             inv_fire;
  logic             wb_fire;
  logic             enter_fatal;
  logic             dirty_eff;
  logic [IDX_W-1:0] loc_idx;
  logic [WAY_W-1:0] loc_way;
  logic             loc_corr;
  logic             loc_dirty;
  logic             wb_needed;
  logic             fatal_hit;

  // Instruction lines are read-only in the cache, so dirtiness is meaningless there.
  generate
    if (DATA_SIDE) begin : g_data
      assign dirty_eff = line_dirty;
    end else begin : g_instr
      assign dirty_eff = 1'b0;
    end
  endgenerate

  ecc_rec_capture #(.IDX_W(IDX_W), .WAY_W(WAY_W)) u_capture (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (accept),
    .idx_in   (err_index),
    .way_in   (err_way),
    .corr_in  (err_correctable),
    .dirty_in (dirty_eff),
    .idx_q    (loc_idx),
    .way_q    (loc_way),
    .corr_q   (loc_corr),
    .dirty_q  (loc_dirty)
  );

  assign wb_needed = needs_writeback(DATA_SIDE, loc_dirty, loc_corr);
  assign fatal_hit = is_fatal(DATA_SIDE, loc_dirty, loc_corr);

  ecc_rec_fsm #(.DATA_SIDE(DATA_SIDE)) u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .err_valid   (err_valid),
    .wb_needed   (wb_needed),
    .fatal_hit   (fatal_hit),
    .inv_done    (inv_done),
    .wb_ready    (wb_ready),
    .fatal_clr   (fatal_clr),
    .busy        (busy),
    .accept      (accept),
    .bank_push   (bank_push),
    .inv_req     (inv_req),
    .inv_fire    (inv_fire),
    .wb_valid    (wb_valid),
    .wb_fire     (wb_fire),
    .retry_pulse (retry_pulse),
    .enter_fatal (enter_fatal)
  );

  ecc_rec_fatal_flag u_fatal (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_i  (enter_fatal),
    .clr_i  (fatal_clr),
    .flag_q (fatal_err)
  );

  assign bank_index = loc_idx;
  assign bank_way   = loc_way;
  assign inv_index  = loc_idx;
  assign inv_way    = loc_way;
  assign wb_index   = loc_idx;
  assign wb_way     = loc_way;

  assert_inv_loc_stable_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (inv_req && !inv_done) |=> ($stable(inv_index) && $stable(inv_way)));
  assert_wb_loc_stable_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_valid && !wb_ready) |=> ($stable(wb_index) && $stable(wb_way)));
  assert_push_follows_accept_R2: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (bank_push && bank_index == $past(err_index) && bank_way == $past(err_way)));
  assert_fatal_no_inv_R7: assert property (@(posedge clk) disable iff (!rst_n)
    fatal_err |-> (!inv_req && !retry_pulse && busy));
  assert_ignore_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !retry_pulse) |=> $stable(inv_index));

endmodule

// File: tb/ecc_recovery_seq_tb.sv
module ecc_recovery_seq_tb;

  localparam int IDX_W = 7;
  localparam int WAY_W = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic             sel_data;
  logic             ev;
  logic [IDX_W-1:0] e_idx;
  logic [WAY_W-1:0] e_way;
  logic             e_corr, e_dirty;
  logic             inv_done, wb_ready, fatal_clr;

  logic             d_busy, d_push, d_inv, d_wbv, d_retry, d_fatal;
  logic [IDX_W-1:0] d_bidx, d_iidx, d_widx;
  logic [WAY_W-1:0] d_bway, d_iway, d_wway;
  logic             i_busy, i_push, i_inv, i_wbv, i_retry, i_fatal;
  logic [IDX_W-1:0] i_bidx, i_iidx, i_widx;
  logic [WAY_W-1:0] i_bway, i_iway, i_wway;

  ecc_recovery_seq #(.IDX_W(IDX_W), .WAY_W(WAY_W), .DATA_SIDE(1'b1)) u_dut (
    .clk(clk), .rst_n(rst_n), .err_valid(ev & sel_data), .err_index(e_idx), .err_way(e_way),
    .err_correctable(e_corr), .line_dirty(e_dirty), .busy(d_busy), .bank_push(d_push),
    .bank_index(d_bidx), .bank_way(d_bway), .inv_req(d_inv), .inv_index(d_iidx),
    .inv_way(d_iway), .inv_done(inv_done), .wb_valid(d_wbv), .wb_index(d_widx),
    .wb_way(d_wway), .wb_ready(wb_ready), .retry_pulse(d_retry), .fatal_err(d_fatal),
    .fatal_clr(fatal_clr));

  ecc_recovery_seq #(.IDX_W(IDX_W), .WAY_W(WAY_W), .DATA_SIDE(1'b0)) u_dut_isd (
    .clk(clk), .rst_n(rst_n), .err_valid(ev & ~sel_data), .err_index(e_idx), .err_way(e_way),
    .err_correctable(e_corr), .line_dirty(e_dirty), .busy(i_busy), .bank_push(i_push),
    .bank_index(i_bidx), .bank_way(i_bway), .inv_req(i_inv), .inv_index(i_iidx),
    .inv_way(i_iway), .inv_done(inv_done), .wb_valid(i_wbv), .wb_index(i_widx),
    .wb_way(i_wway), .wb_ready(wb_ready), .retry_pulse(i_retry), .fatal_err(i_fatal),
    .fatal_clr(fatal_clr));

  // Observed view of whichever side is under test.
  logic             o_busy, o_push, o_inv, o_wbv, o_retry, o_fatal;
  logic [IDX_W-1:0] o_bidx, o_iidx, o_widx;
  logic [WAY_W-1:0] o_bway, o_iway, o_wway;
  always_comb begin
    if (sel_data) begin
      {o_busy, o_push, o_inv, o_wbv, o_retry, o_fatal} = {d_busy, d_push, d_inv, d_wbv, d_retry, d_fatal};
      {o_bidx, o_iidx, o_widx, o_bway, o_iway, o_wway} = {d_bidx, d_iidx, d_widx, d_bway, d_iway, d_wway};
    end else begin
      {o_busy, o_push, o_inv, o_wbv, o_retry, o_fatal} = {i_busy, i_push, i_inv, i_wbv, i_retry, i_fatal};
      {o_bidx, o_iidx, o_widx, o_bway, o_iway, o_wway} = {i_bidx, i_iidx, i_widx, i_bway, i_iway, i_wway};
    end
  end

  int checks = 0;
  int fails  = 0;
  bit finished = 1'b0;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  // Expected-behaviour functions, written from the requirements.
  function automatic bit exp_writeback(bit data, bit dirty, bit corr);
    if (!data) return 1'b0;
    return dirty && corr;
  endfunction

  function automatic bit exp_fatal(bit data, bit dirty, bit corr);
    return data ? (dirty && !corr) : 1'b0;
  endfunction

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic run_error(bit data, logic [IDX_W-1:0] idx, logic [WAY_W-1:0] way,
                           bit corr, bit dirty, int inv_lat, int wb_lat, bit poke);
    bit fat = exp_fatal(data, dirty, corr);
    bit wb  = exp_writeback(data, dirty, corr);
    sel_data = data;
    ev = 1'b1; e_idx = idx; e_way = way; e_corr = corr; e_dirty = dirty;
    @(posedge clk);
    @(negedge clk);
    ev = 1'b0;
    chk("R2 busy", o_busy, 1);
    chk("R2 bank_push", o_push, 1);
    chk("R2 bank_index", o_bidx, idx);
    chk("R2 bank_way", o_bway, way);
    step();
    chk("R2 push single", o_push, 0);
    if (fat) begin
      chk("R7 fatal_err", o_fatal, 1);
      chk("R7 no inv_req", o_inv, 0);
      for (int k = 0; k < inv_lat + 1; k++) begin
        step();
        chk("R8 fatal sticky", o_fatal, 1);
        chk("R7 no retry", o_retry, 0);
        chk("R7 still busy", o_busy, 1);
      end
      fatal_clr = 1'b1;
      step();
      fatal_clr = 1'b0;
      chk("R8 fatal cleared", o_fatal, 0);
      chk("R8 idle after clear", o_busy, 0);
      return;
    end
    chk("R3 inv_req", o_inv, 1);
    chk("R3 inv_index", o_iidx, idx);
    chk("R3 inv_way", o_iway, way);
    chk("R4 not fatal", o_fatal, 0);
    for (int k = 0; k < inv_lat; k++) begin
      if (poke && k == 0) begin
        ev = 1'b1; e_idx = ~idx; e_way = ~way;
      end
      step();
      ev = 1'b0;
      chk("R3 inv held", o_inv, 1);
      chk("R10 inv_index kept", o_iidx, idx);
      chk("R10 no second push", o_push, 0);
      chk("R3 no early retry", o_retry, 0);
    end
    inv_done = 1'b1;
    step();
    inv_done = 1'b0;
    chk("R3 inv dropped", o_inv, 0);
    if (wb) begin
      chk("R5 wb_valid", o_wbv, 1);
      chk("R5 wb_index", o_widx, idx);
      chk("R5 wb_way", o_wway, way);
      chk("R5 no early retry", o_retry, 0);
      for (int k = 0; k < wb_lat; k++) begin
        step();
        chk("R5 wb held", o_wbv, 1);
        chk("R5 wb_index kept", o_widx, idx);
      end
      wb_ready = 1'b1;
      step();
      wb_ready = 1'b0;
      chk("R5 wb dropped", o_wbv, 0);
    end else begin
      chk(data ? "R6 no writeback" : "R4 no writeback", o_wbv, 0);
    end
    chk("R9 retry_pulse", o_retry, 1);
    chk("R9 busy in retry", o_busy, 1);
    step();
    chk("R9 retry single", o_retry, 0);
    chk("R9 idle after retry", o_busy, 0);
    chk("R10 no extra push", o_push, 0);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual %0d expected below 100000 cycles", cyc);
      finish_run();
    end
  end

  initial begin
    sel_data = 1'b1; ev = 1'b0; e_idx = '0; e_way = '0; e_corr = 1'b1; e_dirty = 1'b0;
    inv_done = 1'b0; wb_ready = 1'b0; fatal_clr = 1'b0;
    void'($urandom(32'h5eed_0c7a));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    for (int s = 0; s < 2; s++) begin
      sel_data = s[0];
      #0;
      chk("R1 busy", o_busy, 0);
      chk("R1 bank_push", o_push, 0);
      chk("R1 inv_req", o_inv, 0);
      chk("R1 wb_valid", o_wbv, 0);
      chk("R1 retry", o_retry, 0);
      chk("R1 fatal", o_fatal, 0);
    end
    // Directed corner cases.
    run_error(1'b0, 7'h7f, 2'd3, 1'b0, 1'b1, 2, 0, 1'b1); // R4 instruction side, dirty+uncorrectable
    run_error(1'b1, 7'h00, 2'd0, 1'b1, 1'b1, 0, 0, 1'b0); // R5 zero latency
    run_error(1'b1, 7'h2a, 2'd1, 1'b1, 1'b1, 3, 4, 1'b1); // R5 with waits
    run_error(1'b1, 7'h15, 2'd2, 1'b0, 1'b0, 1, 0, 1'b0); // R6 clean uncorrectable
    run_error(1'b1, 7'h33, 2'd3, 1'b1, 1'b0, 2, 0, 1'b0); // R6 clean correctable
    run_error(1'b1, 7'h41, 2'd1, 1'b0, 1'b1, 2, 0, 1'b0); // R7 / R8 fatal
    run_error(1'b1, 7'h42, 2'd2, 1'b1, 1'b1, 1, 1, 1'b0); // recovery after fatal clear
    // Constrained random traffic.
    for (int n = 0; n < 80; n++) begin
      run_error(1'($urandom), IDX_W'($urandom), WAY_W'($urandom), 1'($urandom), 1'($urandom),
                int'($urandom % 5), int'($urandom % 5), 1'($urandom));
    end
    finish_run();
  end

endmodule